// File: doc/BRIEF.md
# SDRAM power-on and self-refresh sequencer

This block drives the command bus of an SDRAM during its two housekeeping sequences: the initialization that follows power-up, and the transitions into and out of self-refresh. Software starts these through a small control word. Its fields are a power-on trigger, a self-refresh request level and a 3-bit refresh burst count. A static configuration (burst length code, CAS latency, write-burst enable) supplies the mode-register value written during initialization.

The block emits exactly one command per clock. Parameterized minimum gaps follow PALL (`T_RP`), every REF (`T_RFC`), the mode-register write (`T_MRD`) and the self-refresh exit (`T_XSR`), and NOP fills every gap. A `ready` flag tells the normal access path when it may issue its own traffic. A normal-path access that arrives while the memory is busy or asleep is held as pending. In self-refresh, a pending access wakes the memory automatically. This also covers an access raised by a DMA engine while the processor sleeps.

Top module: `sdr_pwr_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the block drives NOP with `ready`, `in_self` and `acc_pend` low, and it stays that way until power-on is written.
- R2: A control write with `ctl_pon`=1 from the uninitialized or ready state issues PALL, then exactly eight REF, then MRS. Commands on `cmd` are coded NOP=0, PALL=1, REF=2, MRS=3, SELF=4, SELFX=5. The first REF comes `T_RP` cycles after PALL, each further REF and the MRS come `T_RFC` cycles after the previous REF, and `ready` rises `T_MRD` cycles after MRS.
- R3: In the MRS cycle `mode_word` carries the burst length code in bits 2:0, the CAS latency in bits 6:4, and bit 9 set when `cfg_wbst` is 0 (single writes); all other bits are 0. In every other cycle `mode_word` is 0.
- R4: In the ready state, a set self-refresh bit with a count N of 1 to 7 issues N REF commands `T_RFC` apart, followed by SELF `T_RFC` after the last REF.
- R5: A count of 0 skips both refresh bursts. SELF is issued directly, and after SELFX `ready` returns `T_XSR` cycles later.
- R6: In self-refresh, clearing the self-refresh bit issues SELFX, then N REF commands (the first `T_XSR` after SELFX, the rest `T_RFC` apart), and `ready` rises `T_RFC` after the last REF.
- R7: In self-refresh, a pending access issues SELFX on the next cycle and clears the self-refresh bit, so the block does not go back to sleep after the exit completes.
- R8: `ready` is low from the cycle of the first command of any sequence until its final gap expires, and NOP is on `cmd` whenever `ready` is high.
- R9: An `acc_req` pulse seen while `ready` is low sets `acc_pend`. `acc_pend` stays set until `ready` is high, and clears the cycle after.
- R10: A self-refresh request written before initialization completes issues no SELF during initialization. It takes effect once the ready state is reached.
- R11: `in_self` rises in the cycle SELF is on `cmd` and falls in the cycle SELFX is on `cmd`.
- R12: A power-on write during a running sequence or during self-refresh has no effect on `cmd`, `ready` or `in_self`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_we | input | 1 | Control word write strobe |
| ctl_pon | input | 1 | Power-on trigger, acted on when written as 1 |
| ctl_self | input | 1 | Self-refresh request level |
| ctl_rcnt | input | 3 | Refresh burst count around self-refresh |
| cfg_bl | input | 3 | Burst length code for the mode word |
| cfg_cl | input | 3 | CAS latency for the mode word |
| cfg_wbst | input | 1 | 1 = burst writes, 0 = single writes |
| acc_req | input | 1 | Access request pulse from the normal path |
| cmd | output | 3 | Command issued this cycle |
| mode_word | output | MODE_W | Mode-register value, valid with MRS |
| ready | output | 1 | Normal access allowed |
| in_self | output | 1 | Memory is in self-refresh |
| acc_pend | output | 1 | An access is waiting for `ready` |

## Verification
Initialization is run twice, with different configuration values, so that the mode-word field positions and the write-burst polarity are told apart. Self-refresh is entered with counts 0, 2, 3 and 7. This separates the skipped burst from real bursts and catches an off-by-one in the refresh count. Exit is provoked once by clearing the request bit and once by an access pulse, which tells the two wake-up causes apart and shows whether the request bit is cleared. Accesses and power-on writes are also injected in the middle of sequences, to show that pending accesses are kept and that power-on writes made while busy are dropped.

// File: rtl/sdr_pwr_pkg.sv
package sdr_pwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_PALL  = 3'd1,
    CMD_REF   = 3'd2,
    CMD_MRS   = 3'd3,
    CMD_SELF  = 3'd4,
    CMD_SELFX = 3'd5
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_INIT_REF,
    ST_INIT_MRS,
    ST_INIT_FIN,
    ST_NORMAL,
    ST_ENTER,
    ST_SELFREF,
    ST_EXIT
  } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R2: an idle timer never wraps around from zero
  a_r2_gap_rests_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int MODE_W = 13
) (
  input  logic [2:0]        bl_code,
  input  logic [2:0]        cas_lat,
  input  logic              wr_burst,
  output logic [MODE_W-1:0] word
);

  always_comb begin
    word      = '0;
    word[2:0] = bl_code;
    word[6:4] = cas_lat;
    word[9]   = ~wr_burst;
  end

endmodule

// File: rtl/sdr_ctl_regs.sv
module sdr_ctl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_self,
  input  logic [2:0] ctl_rcnt,
  input  logic       self_clr,
  input  logic       acc_req,
  input  logic       ready_q,
  output logic       self_q,
  output logic [2:0] rcnt_q,
  output logic       pend_q
);

  logic self_d;
  logic self_en;
  logic pend_d;
  logic pend_en;

  always_comb begin
    self_en = ctl_we || self_clr;
    self_d  = ctl_we ? ctl_self : 1'b0;
    pend_en = ready_q || acc_req;
    pend_d  = ready_q ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      self_q <= 1'b0;
      rcnt_q <= 3'd0;
      pend_q <= 1'b0;
    end else begin
      if (self_en) self_q <= self_d;
      if (ctl_we)  rcnt_q <= ctl_rcnt;
      if (pend_en) pend_q <= pend_d;
    end
  end

  // R9: a held access survives until ready is granted
  a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ready_q) |=> pend_q);

  // R9: a pending access is released once ready has been seen
  a_r9_pend_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !acc_req) |=> !pend_q);

endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
  import sdr_pwr_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 10,
  parameter int INIT_REFS = 8,
  parameter int MODE_W    = 13,
  parameter int CW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pon_go,
  input  logic              self_q,
  input  logic [2:0]        rcnt_q,
  input  logic              pend_q,
  input  logic              acc_req,
  input  logic              gap_expired,
  input  logic [MODE_W-1:0] mode_calc,
  output sdr_cmd_e          cmd_q,
  output logic              ready_q,
  output logic              in_self_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              self_clr,
  output logic              gap_load,
  output logic [CW-1:0]     gap_val
);

  localparam int RMAX = (INIT_REFS > 7) ? INIT_REFS : 7;
  localparam int RW   = $clog2(RMAX + 1);

  localparam logic [CW-1:0] GAP_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] GAP_RFC = CW'(T_RFC - 1);
  localparam logic [CW-1:0] GAP_MRD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] GAP_XSR = CW'(T_XSR - 1);

  seq_state_e        st_q, st_d;
  logic [RW-1:0]     rleft_q, rleft_d;
  sdr_cmd_e          cmd_d;
  logic              ready_d;
  logic              in_self_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    st_d     = st_q;
    rleft_d  = rleft_q;
    cmd_d    = CMD_NOP;
    gap_load = 1'b0;
    gap_val  = '0;
    self_clr = 1'b0;

    case (st_q)
      ST_UNINIT: begin
        if (pon_go) begin
          cmd_d    = CMD_PALL;
          gap_load = 1'b1;
          gap_val  = GAP_RP;
          rleft_d  = RW'(INIT_REFS);
          st_d     = ST_INIT_REF;
        end
      end
      ST_INIT_REF: begin
        if (gap_expired) begin
          cmd_d    = CMD_REF;
          gap_load = 1'b1;
          gap_val  = GAP_RFC;
          rleft_d  = rleft_q - 1'b1;
          if (rleft_q == RW'(1)) st_d = ST_INIT_MRS;
        end
      end
      ST_INIT_MRS: begin
        if (gap_expired) begin
          cmd_d    = CMD_MRS;
          gap_load = 1'b1;
          gap_val  = GAP_MRD;
          st_d     = ST_INIT_FIN;
        end
      end
      ST_INIT_FIN: begin
        if (gap_expired) st_d = ST_NORMAL;
      end
      ST_NORMAL: begin
        if (pon_go) begin
          cmd_d    = CMD_PALL;
          gap_load = 1'b1;
          gap_val  = GAP_RP;
          rleft_d  = RW'(INIT_REFS);
          st_d     = ST_INIT_REF;
        end else if (self_q && !acc_req && !pend_q) begin
          if (rcnt_q == 3'd0) begin
            cmd_d = CMD_SELF;
            st_d  = ST_SELFREF;
          end else begin
            cmd_d    = CMD_REF;
            gap_load = 1'b1;
            gap_val  = GAP_RFC;
            rleft_d  = RW'(rcnt_q) - 1'b1;
            st_d     = ST_ENTER;
          end
        end
      end
      ST_ENTER: begin
        if (gap_expired) begin
          if (rleft_q != '0) begin
            cmd_d    = CMD_REF;
            gap_load = 1'b1;
            gap_val  = GAP_RFC;
            rleft_d  = rleft_q - 1'b1;
          end else begin
            cmd_d = CMD_SELF;
            st_d  = ST_SELFREF;
          end
        end
      end
      ST_SELFREF: begin
        if (!self_q || pend_q) begin
          cmd_d    = CMD_SELFX;
          gap_load = 1'b1;
          gap_val  = GAP_XSR;
          rleft_d  = RW'(rcnt_q);
          self_clr = pend_q;
          st_d     = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (gap_expired) begin
          if (rleft_q != '0) begin
            cmd_d    = CMD_REF;
            gap_load = 1'b1;
            gap_val  = GAP_RFC;
            rleft_d  = rleft_q - 1'b1;
          end else begin
            st_d = ST_NORMAL;
          end
        end
      end
      default: st_d = ST_UNINIT;
    endcase

    ready_d   = (st_d == ST_NORMAL);
    in_self_d = (cmd_d == CMD_SELF) ? 1'b1 :
                (cmd_d == CMD_SELFX) ? 1'b0 : in_self_q;
    mode_d    = (cmd_d == CMD_MRS) ? mode_calc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_UNINIT;
      rleft_q   <= '0;
      cmd_q     <= CMD_NOP;
      ready_q   <= 1'b0;
      in_self_q <= 1'b0;
      mode_q    <= '0;
    end else begin
      st_q      <= st_d;
      rleft_q   <= rleft_d;
      cmd_q     <= cmd_d;
      ready_q   <= ready_d;
      in_self_q <= in_self_d;
      mode_q    <= mode_d;
    end
  end

  // R8: the bus is quiet while the normal path owns it
  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (cmd_q == CMD_NOP));

  // R8: no access grant while the memory sleeps
  a_r8_asleep_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_self_q |-> !ready_q);

  // R11: status follows the sleep command
  a_r11_self_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_SELF) |-> in_self_q);

  // R11: status follows the wake command
  a_r11_selfx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_SELFX) |-> !in_self_q);

  // R7: a pending access wakes the memory on the next cycle
  a_r7_access_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SELFREF && pend_q) |=> (cmd_q == CMD_SELFX));

  // R3: the mode word is zero outside the MRS cycle
  a_r3_word_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_MRS) |-> (mode_q == '0));

endmodule

// File: rtl/sdr_pwr_seq.sv
module sdr_pwr_seq
  import sdr_pwr_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 10,
  parameter int INIT_REFS = 8,
  parameter int MODE_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_pon,
  input  logic              ctl_self,
  input  logic [2:0]        ctl_rcnt,
  input  logic [2:0]        cfg_bl,
  input  logic [2:0]        cfg_cl,
  input  logic              cfg_wbst,
  input  logic              acc_req,
  output logic [2:0]        cmd,
  output logic [MODE_W-1:0] mode_word,
  output logic              ready,
  output logic              in_self,
  output logic              acc_pend
);

  localparam int GAP_MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GAP_MAX_B = (T_MRD > T_XSR) ? T_MRD : T_XSR;
  localparam int GAP_MAX   = (GAP_MAX_A > GAP_MAX_B) ? GAP_MAX_A : GAP_MAX_B;
  localparam int CW        = $clog2(GAP_MAX + 1);

  logic              pon_go;
  logic              self_q;
  logic [2:0]        rcnt_q;
  logic              pend_q;
  logic              self_clr;
  logic              ready_q;
  logic              gap_load;
  logic [CW-1:0]     gap_val;
  logic              gap_expired;
  logic [MODE_W-1:0] mode_calc;
  sdr_cmd_e          cmd_w;

  assign pon_go = ctl_we && ctl_pon;

  sdr_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_self (ctl_self),
    .ctl_rcnt (ctl_rcnt),
    .self_clr (self_clr),
    .acc_req  (acc_req),
    .ready_q  (ready_q),
    .self_q   (self_q),
    .rcnt_q   (rcnt_q),
    .pend_q   (pend_q)
  );

  sdr_mode_word #(.MODE_W(MODE_W)) u_mword (
    .bl_code  (cfg_bl),
    .cas_lat  (cfg_cl),
    .wr_burst (cfg_wbst),
    .word     (mode_calc)
  );

  sdr_gap_timer #(.CW(CW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_expired)
  );

  sdr_seq_fsm #(
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .T_MRD     (T_MRD),
    .T_XSR     (T_XSR),
    .INIT_REFS (INIT_REFS),
    .MODE_W    (MODE_W),
    .CW        (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pon_go      (pon_go),
    .self_q      (self_q),
    .rcnt_q      (rcnt_q),
    .pend_q      (pend_q),
    .acc_req     (acc_req),
    .gap_expired (gap_expired),
    .mode_calc   (mode_calc),
    .cmd_q       (cmd_w),
    .ready_q     (ready_q),
    .in_self_q   (in_self),
    .mode_q      (mode_word),
    .self_clr    (self_clr),
    .gap_load    (gap_load),
    .gap_val     (gap_val)
  );

  assign cmd      = cmd_w;
  assign ready    = ready_q;
  assign acc_pend = pend_q;

endmodule

// File: tb/sdr_pwr_seq_test.sv
module sdr_pwr_seq_test;

  localparam int TB_RP  = 2;
  localparam int TB_RFC = 3;
  localparam int TB_MRD = 2;
  localparam int TB_XSR = 4;
  localparam int MW     = 13;

  localparam int C_NOP = 0, C_PALL = 1, C_REF = 2, C_MRS = 3, C_SELF = 4, C_SELFX = 5, C_DONE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0, ctl_pon = 1'b0, ctl_self = 1'b0;
  logic [2:0]    ctl_rcnt = 3'd0;
  logic [2:0]    cfg_bl = 3'd0, cfg_cl = 3'd0;
  logic          cfg_wbst = 1'b0;
  logic          acc_req = 1'b0;
  logic [2:0]    cmd;
  logic [MW-1:0] mode_word;
  logic          ready, in_self, acc_pend;

  sdr_pwr_seq #(.T_RP(TB_RP), .T_RFC(TB_RFC), .T_MRD(TB_MRD), .T_XSR(TB_XSR),
                .INIT_REFS(8), .MODE_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_pon(ctl_pon),
    .ctl_self(ctl_self), .ctl_rcnt(ctl_rcnt), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .cfg_wbst(cfg_wbst), .acc_req(acc_req), .cmd(cmd), .mode_word(mode_word),
    .ready(ready), .in_self(in_self), .acc_pend(acc_pend)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    q[$];
  int    m_mode = 0;       // 0 uninit, 1 ready state, 2 asleep
  bit    m_self = 0;
  int    m_rcnt = 0;
  bit    m_pend = 0;
  int    exp_cmd = 0, exp_mode = 0;
  bit    exp_ready = 0, exp_inself = 0, exp_pend = 0;
  string m_tag = "R1";

  task automatic push_gap(int c, int gap);
    q.push_back(c);
    for (int i = 1; i < gap; i++) q.push_back(C_NOP);
  endtask

  task automatic build_init();
    push_gap(C_PALL, TB_RP);
    for (int i = 0; i < 8; i++) push_gap(C_REF, TB_RFC);
    push_gap(C_MRS, TB_MRD);
    q.push_back(C_DONE);
    m_mode = 1;
    m_tag  = "R2";
  endtask

  task automatic build_entry(int n);
    for (int i = 0; i < n; i++) push_gap(C_REF, TB_RFC);
    q.push_back(C_SELF);
    m_mode = 2;
    m_tag  = (n == 0) ? "R5" : "R4";
  endtask

  task automatic build_exit(int n, bit by_acc);
    push_gap(C_SELFX, TB_XSR);
    for (int i = 0; i < n; i++) push_gap(C_REF, TB_RFC);
    q.push_back(C_DONE);
    m_mode = 1;
    m_tag  = by_acc ? "R7" : ((n == 0) ? "R5" : "R6");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 0; m_self = 0; m_rcnt = 0; m_pend = 0;
      exp_cmd = 0; exp_mode = 0; exp_ready = 0; exp_inself = 0; exp_pend = 0;
      m_tag = "R1";
    end else begin
      bit old_pend, old_self, old_ready, clr, popped, pon;
      int old_rcnt, c;
      old_pend = m_pend; old_self = m_self; old_rcnt = m_rcnt; old_ready = exp_ready;
      clr = 0; popped = 0; c = C_NOP;
      pon = ctl_we && ctl_pon;
      if (q.size() == 0) begin
        if (m_mode == 0) begin
          if (pon) build_init();
        end else if (m_mode == 1) begin
          if (pon) build_init();
          else if (old_self && !acc_req && !old_pend) build_entry(old_rcnt);
        end else begin
          if (!old_self || old_pend) begin
            build_exit(old_rcnt, old_pend);
            clr = old_pend;
          end
        end
      end
      if (q.size() > 0) begin
        c = q.pop_front();
        popped = 1;
      end
      exp_ready = (m_mode == 1) && (!popped || c == C_DONE);
      if (c == C_DONE) c = C_NOP;
      exp_cmd = c;
      if (c == C_SELF)  exp_inself = 1;
      if (c == C_SELFX) exp_inself = 0;
      exp_mode = (c == C_MRS) ? (int'(cfg_bl) | (int'(cfg_cl) << 4) | (int'(!cfg_wbst) << 9)) : 0;
      m_pend = old_ready ? 1'b0 : (old_pend | acc_req);
      if (ctl_we) begin
        m_self = ctl_self;
        m_rcnt = int'(ctl_rcnt);
      end else if (clr) begin
        m_self = 0;
      end
      exp_pend = m_pend;
      if (q.size() == 0 && m_mode == 1 && !popped) m_tag = "R8";
    end
  end

  // ---------------- per-cycle comparison ----------------
  int n_ref = 0;
  bit in_init = 0;

  always @(negedge clk) begin
    if (!done) begin
      chk(m_tag, "cmd", int'(cmd), exp_cmd);
      chk("R8", "ready", int'(ready), int'(exp_ready));
      chk("R11", "in_self", int'(in_self), int'(exp_inself));
      chk("R3", "mode_word", int'(mode_word), exp_mode);
      chk("R9", "acc_pend", int'(acc_pend), int'(exp_pend));
      if (int'(cmd) == C_PALL) begin
        n_ref = 0;
        in_init = 1;
      end else if (int'(cmd) == C_REF && in_init) begin
        n_ref++;
      end else if (int'(cmd) == C_MRS) begin
        chk("R2", "refs before MRS", n_ref, 8);
        in_init = 0;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit pon, bit slf, int rc);
    ctl_we = 1; ctl_pon = pon; ctl_self = slf; ctl_rcnt = 3'(rc);
    @(negedge clk);
    ctl_we = 0; ctl_pon = 0;
  endtask

  task automatic pulse_acc();
    acc_req = 1;
    @(negedge clk);
    acc_req = 0;
  endtask

  task automatic wait_for(int c, string tag);
    int k;
    k = 0;
    while (int'(cmd) != c && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(tag, "expected command reached", int'(cmd), c);
  endtask

  task automatic wait_ready(string tag);
    int k;
    k = 0;
    while (!ready && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(tag, "ready reached", int'(ready), 1);
  endtask

  initial begin
    idle(3);
    // R1: outputs while reset is held
    chk("R1", "cmd in reset", int'(cmd), C_NOP);
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "in_self in reset", int'(in_self), 0);
    rst_n = 1;
    idle(3);
    chk("R1", "ready after release", int'(ready), 0);

    // R10: sleep request written before initialization
    wr(0, 1, 2);
    idle(4);
    chk("R10", "no sleep before init", int'(in_self), 0);
    cfg_bl = 3'd3; cfg_cl = 3'd2; cfg_wbst = 1'b1;
    wr(1, 1, 2);
    wait_for(C_SELF, "R10");
    idle(2);
    // R12: power-on write while asleep is dropped
    wr(1, 1, 2);
    idle(5);
    chk("R12", "still asleep", int'(in_self), 1);
    chk("R12", "no command", int'(cmd), C_NOP);
    // R6: wake by clearing the request
    wr(0, 0, 2);
    wait_ready("R6");
    idle(3);

    // R4 entry with the largest count, R7 wake by an access
    wr(0, 1, 7);
    wait_for(C_SELF, "R4");
    idle(3);
    pulse_acc();
    wait_ready("R7");
    idle(6);
    chk("R7", "no return to sleep", int'(in_self), 0);

    // R5: count of zero
    wr(0, 1, 0);
    wait_for(C_SELF, "R5");
    idle(2);
    wr(0, 0, 0);
    wait_ready("R5");
    idle(2);

    // R9: access during an entry burst is kept and wakes the memory
    wr(0, 1, 3);
    idle(2);
    pulse_acc();
    chk("R9", "access held", int'(acc_pend), 1);
    wait_ready("R9");
    idle(3);

    // R3 with new field values, R9 and R12 during initialization
    cfg_bl = 3'd7; cfg_cl = 3'd3; cfg_wbst = 1'b0;
    wr(1, 0, 3);
    idle(3);
    pulse_acc();
    chk("R9", "access held in init", int'(acc_pend), 1);
    idle(2);
    wr(1, 0, 3);
    wait_ready("R2");
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule